// File: doc/BRIEF.md
# Serial Pattern Generator and Error Checker

This engine drives a one-bit-per-clock test stream out of a link and checks a stream coming back in. Three stream kinds can be selected: a 15-bit maximal-length pseudorandom sequence, one programmable 16-bit word sent over and over, or two 16-bit words that take turns, each sent a programmable number of times before the other takes over. The transmit side and the receive side have separate enables, so the engine can act as a source only, a sink only, or both at once in a loopback.

The receive side has no framing and needs none. It watches the incoming bits, finds its place in the selected pattern by itself, and from then on predicts every bit and compares. Each compared bit and each mismatch is counted in a saturating counter. Software reads the counters through a small word-addressed register port; reading the bit counter clears both counters and the overflow flag, so each read returns one measurement period. The error ratio is left to software: the error count divided by the bit count.

A command bit forces a single inverted bit into the transmit stream. Looping that stream back yields exactly one counted error, which tests the whole path end to end.

Top module: `bert_engine`

## Requirements
- R1: In pseudorandom mode (CTRL[1:0] = 0, and code 3 acts the same) the transmitted bit is s[14] XOR s[13] of a 15-bit state s, which then shifts left with that bit entering at s[0]; after reset or a mode change s is all ones.
- R2: In fixed-word mode (CTRL[1:0] = 1) the word in WORDS[15:0] is sent again and again, most significant bit first.
- R3: In alternating mode (CTRL[1:0] = 2) word A (WORDS[15:0]) is sent N times, then word B (WORDS[31:16]) N times, and so on, each MSB first, where N is REPEAT[15:0] at offset 0x1100 and a value of 0 acts as 1.
- R4: The receive side locks with no outside help: in pseudorandom mode it seeds its own state from the first 15 received bits, in fixed-word mode it locks when the last 16 bits equal word A, and in alternating mode when word B is directly followed by word A; STATUS[1] shows the lock.
- R5: While locked, each received bit adds one to the bit counter (BITCNT, 0x1200) and each mismatch with the prediction adds one to the error counter (ERRCNT, 0x1204); bits received while not locked are not counted.
- R6: When 16 mismatches build up inside one 64-bit window, the checker drops lock, stops counting and hunts again.
- R7: Reading BITCNT returns its value and clears both counters and the overflow flag at the same time; the error count and the flag are held for later reads of ERRCNT and STATUS[0]. A bit compared in the same cycle as that read counts toward the next period, so no bit is lost or counted twice.
- R8: Counters stop at their maximum value and do not wrap, and an attempt to go past it sets a sticky overflow flag, read at STATUS[0] after the next BITCNT read.
- R9: CTRL[2] enables the transmit side (tx_valid high one cycle after it is set, low otherwise) and CTRL[3] enables the receive side; while CTRL[3] is low nothing is counted.
- R10: A CTRL write that changes the mode restarts both pattern states, including the word-repeat position, from the beginning.
- R11: Writing CTRL with bit 4 set inverts exactly the next transmitted bit and no other.
- R12: After reset, tx_valid, reg_rdata and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| tx_bit | output | 1 | Transmitted test bit |
| tx_valid | output | 1 | tx_bit carries a pattern bit this cycle |
| rx_en | input | 1 | rx_bit carries a received bit this cycle |
| rx_bit | input | 1 | Received bit |

## Verification
The functions that can meet in one cycle are the clearing read of BITCNT and the counting of a freshly compared bit. The bench keeps a locked stream running without a gap and fires BITCNT reads at random moments into it, then stops the stream, lets the pipeline drain and reads one last time. The sum of all returned counts has to equal the number of bits sent after the opening clear, which shows that a bit landing on the clearing cycle goes into the next period and is neither lost nor counted twice. Saturation meeting a clear is covered by reading a counter that has stuck at its maximum and then reading it again.

// File: rtl/bert_pkg.sv
package bert_pkg;

  typedef enum logic [1:0] {
    MODE_PRBS  = 2'd0,
    MODE_FIXED = 2'd1,
    MODE_ALT   = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  localparam logic [15:0] OFS_CTRL   = 16'h1000;
  localparam logic [15:0] OFS_WORDS  = 16'h1004;
  localparam logic [15:0] OFS_REPEAT = 16'h1100;
  localparam logic [15:0] OFS_BITS   = 16'h1200;
  localparam logic [15:0] OFS_ERRS   = 16'h1204;
  localparam logic [15:0] OFS_STATUS = 16'h1208;

  localparam int CTRL_GEN_BIT = 2;
  localparam int CTRL_CHK_BIT = 3;
  localparam int CTRL_INJ_BIT = 4;

  function automatic logic mode_is_prbs(mode_e m);
    return (m == MODE_PRBS) || (m == MODE_RSVD);
  endfunction

endpackage

// File: rtl/bert_pattern_gen.sv
module bert_pattern_gen
  import bert_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int REP_W  = 16,
  parameter int LFSR_W = 15,
  parameter int TAP_A  = 15,
  parameter int TAP_B  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              advance,
  input  logic              load_prbs,
  input  logic [LFSR_W-1:0] seed,
  input  logic              load_word,
  input  mode_e             mode,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  input  logic [REP_W-1:0]  rep_eff,
  output logic              pat_bit
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

  logic [LFSR_W-1:0] lfsr;
  logic              sel_b;
  logic [REP_W-1:0]  rep_cnt;
  logic [BIT_W-1:0]  bidx;

  logic              prbs_bit;
  logic [WORD_W-1:0] cur_word;
  logic              word_end;
  logic              is_prbs;

  assign is_prbs  = mode_is_prbs(mode);
  assign prbs_bit = lfsr[TAP_A-1] ^ lfsr[TAP_B-1];
  assign cur_word = sel_b ? word_b : word_a;
  assign word_end = (bidx == LAST_IDX);
  assign pat_bit  = is_prbs ? prbs_bit : cur_word[LAST_IDX - bidx];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      lfsr    <= '1;
      sel_b   <= 1'b0;
      rep_cnt <= '0;
      bidx    <= '0;
    end else if (load_prbs) begin
      lfsr <= seed;
    end else if (load_word) begin
      // state just after one complete copy of word A
      bidx <= '0;
      if (mode == MODE_ALT && rep_eff <= REP_W'(1)) begin
        sel_b   <= 1'b1;
        rep_cnt <= '0;
      end else begin
        sel_b   <= 1'b0;
        rep_cnt <= REP_W'(1);
      end
    end else if (advance) begin
      if (is_prbs) begin
        lfsr <= {lfsr[LFSR_W-2:0], prbs_bit};
      end else begin
        bidx <= word_end ? '0 : bidx + BIT_W'(1);
        if (word_end) begin
          if (mode == MODE_ALT) begin
            if ((rep_cnt + REP_W'(1)) >= rep_eff) begin
              rep_cnt <= '0;
              sel_b   <= ~sel_b;
            end else begin
              rep_cnt <= rep_cnt + REP_W'(1);
            end
          end else begin
            sel_b   <= 1'b0;
            rep_cnt <= '0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/bert_checker.sv
module bert_checker
  import bert_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int REP_W    = 16,
  parameter int LFSR_W   = 15,
  parameter int TAP_A    = 15,
  parameter int TAP_B    = 14,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_THR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              restart,
  input  mode_e             mode,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  input  logic [REP_W-1:0]  rep_eff,
  input  logic              rx_en,
  input  logic              rx_bit,
  output logic              cmp_o,
  output logic              err_o,
  output logic              in_sync_o
);

  localparam int HIST_W = 2 * WORD_W;
  localparam int FILL_W = $clog2(HIST_W + 1);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int THR_W  = $clog2(LOSS_THR + 1);

  logic [HIST_W-1:0] hist, nxt_hist;
  logic [FILL_W-1:0] fill;
  logic [FILL_W:0]   need;
  logic              locked;
  logic [WIN_W-1:0]  win_cnt;
  logic [THR_W-1:0]  win_err;
  logic              is_prbs, match, go_lock, ref_bit, mism, hold;

  assign is_prbs  = mode_is_prbs(mode);
  assign nxt_hist = {hist[HIST_W-2:0], rx_bit};
  assign hold     = rst || restart || !active;

  always_comb begin
    if (is_prbs) begin
      need  = (FILL_W+1)'(LFSR_W);
      match = 1'b1;
    end else if (mode == MODE_FIXED) begin
      need  = (FILL_W+1)'(WORD_W);
      match = (nxt_hist[WORD_W-1:0] == word_a);
    end else begin
      need  = (FILL_W+1)'(HIST_W);
      match = (nxt_hist[WORD_W-1:0] == word_a) &&
              (nxt_hist[HIST_W-1:WORD_W] == word_b);
    end
  end

  assign go_lock = rx_en && !locked && (({1'b0, fill} + (FILL_W+1)'(1)) >= need) && match;
  assign mism    = rx_bit ^ ref_bit;

  bert_pattern_gen #(
    .WORD_W(WORD_W), .REP_W(REP_W), .LFSR_W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)
  ) u_ref (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart || !active),
    .advance  (rx_en && locked),
    .load_prbs(go_lock && is_prbs),
    .seed     (nxt_hist[LFSR_W-1:0]),
    .load_word(go_lock && !is_prbs),
    .mode     (mode),
    .word_a   (word_a),
    .word_b   (word_b),
    .rep_eff  (rep_eff),
    .pat_bit  (ref_bit)
  );

  always_ff @(posedge clk) begin
    if (hold) begin
      hist    <= '0;
      fill    <= '0;
      locked  <= 1'b0;
      win_cnt <= '0;
      win_err <= '0;
      cmp_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      cmp_o <= 1'b0;
      err_o <= 1'b0;
      if (rx_en) begin
        hist <= nxt_hist;
        if (!locked) begin
          if (fill != FILL_W'(HIST_W)) fill <= fill + FILL_W'(1);
          if (go_lock) begin
            locked  <= 1'b1;
            win_cnt <= '0;
            win_err <= '0;
          end
        end else begin
          cmp_o <= 1'b1;
          err_o <= mism;
          if (mism && ((win_err + THR_W'(1)) >= THR_W'(LOSS_THR))) begin
            locked <= 1'b0;
            fill   <= '0;
          end else if (win_cnt == WIN_W'(WIN_LEN - 1)) begin
            win_cnt <= '0;
            win_err <= '0;
          end else begin
            win_cnt <= win_cnt + WIN_W'(1);
            win_err <= win_err + THR_W'(mism);
          end
        end
      end
    end
  end

  assign in_sync_o = locked;

endmodule

// File: rtl/bert_stats.sv
module bert_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cmp,
  input  logic             err,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [CNT_W-1:0] err_cnt,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      err_cnt <= '0;
      ovf     <= 1'b0;
    end else if (clr) begin
      // same-cycle event opens the next period
      bit_cnt <= CNT_W'(cmp);
      err_cnt <= CNT_W'(err);
      ovf     <= 1'b0;
    end else begin
      if (cmp) begin
        if (bit_cnt == CNT_MAX) ovf <= 1'b1;
        else bit_cnt <= bit_cnt + CNT_W'(1);
      end
      if (err) begin
        if (err_cnt == CNT_MAX) ovf <= 1'b1;
        else err_cnt <= err_cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/bert_engine.sv
module bert_engine
  import bert_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int WORD_W   = 16,
  parameter int REP_W    = 16,
  parameter int LFSR_W   = 15,
  parameter int TAP_A    = 15,
  parameter int TAP_B    = 14,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_THR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_bit,
  output logic              tx_valid,
  input  logic              rx_en,
  input  logic              rx_bit
);

  mode_e             mode_q;
  logic              gen_en, chk_en, inj_pend;
  logic [WORD_W-1:0] word_a, word_b;
  logic [REP_W-1:0]  rep_q, rep_eff;
  logic              wr_ctrl, mode_chg, clr_rd;
  logic              gen_pat, cmp, err, in_sync;
  logic [CNT_W-1:0]  bit_cnt, err_cnt, err_hold;
  logic              ovf, ovf_hold;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign mode_chg = wr_ctrl && (reg_wdata[1:0] != mode_q);
  assign clr_rd   = reg_rd && (reg_addr == ADDR_W'(OFS_BITS));
  assign rep_eff  = (rep_q == '0) ? REP_W'(1) : rep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PRBS;
      gen_en <= 1'b0;
      chk_en <= 1'b0;
      word_a <= '0;
      word_b <= '0;
      rep_q  <= REP_W'(1);
    end else if (reg_wr) begin
      if (wr_ctrl) begin
        mode_q <= mode_e'(reg_wdata[1:0]);
        gen_en <= reg_wdata[CTRL_GEN_BIT];
        chk_en <= reg_wdata[CTRL_CHK_BIT];
      end
      if (reg_addr == ADDR_W'(OFS_WORDS)) begin
        word_a <= reg_wdata[WORD_W-1:0];
        word_b <= reg_wdata[2*WORD_W-1:WORD_W];
      end
      if (reg_addr == ADDR_W'(OFS_REPEAT)) rep_q <= reg_wdata[REP_W-1:0];
    end
  end

  bert_pattern_gen #(
    .WORD_W(WORD_W), .REP_W(REP_W), .LFSR_W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)
  ) u_tx_pat (
    .clk      (clk),
    .rst      (rst),
    .restart  (mode_chg),
    .advance  (gen_en),
    .load_prbs(1'b0),
    .seed     ('0),
    .load_word(1'b0),
    .mode     (mode_q),
    .word_a   (word_a),
    .word_b   (word_b),
    .rep_eff  (rep_eff),
    .pat_bit  (gen_pat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
      inj_pend <= 1'b0;
    end else begin
      tx_valid <= gen_en;
      if (gen_en) tx_bit <= gen_pat ^ inj_pend;
      if (wr_ctrl && reg_wdata[CTRL_INJ_BIT]) inj_pend <= 1'b1;
      else if (gen_en) inj_pend <= 1'b0;
    end
  end

  bert_checker #(
    .WORD_W(WORD_W), .REP_W(REP_W), .LFSR_W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B),
    .WIN_LEN(WIN_LEN), .LOSS_THR(LOSS_THR)
  ) u_chk (
    .clk      (clk),
    .rst      (rst),
    .active   (chk_en),
    .restart  (mode_chg),
    .mode     (mode_q),
    .word_a   (word_a),
    .word_b   (word_b),
    .rep_eff  (rep_eff),
    .rx_en    (rx_en),
    .rx_bit   (rx_bit),
    .cmp_o    (cmp),
    .err_o    (err),
    .in_sync_o(in_sync)
  );

  bert_stats #(.CNT_W(CNT_W)) u_stats (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_rd),
    .cmp    (cmp),
    .err    (err),
    .bit_cnt(bit_cnt),
    .err_cnt(err_cnt),
    .ovf    (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      err_hold  <= '0;
      ovf_hold  <= 1'b0;
    end else if (reg_rd) begin
      if (clr_rd) begin
        err_hold <= err_cnt;
        ovf_hold <= ovf;
      end
      unique case (reg_addr)
        ADDR_W'(OFS_CTRL):   reg_rdata <= DATA_W'({chk_en, gen_en, mode_q});
        ADDR_W'(OFS_WORDS):  reg_rdata <= DATA_W'({word_b, word_a});
        ADDR_W'(OFS_REPEAT): reg_rdata <= DATA_W'(rep_q);
        ADDR_W'(OFS_BITS):   reg_rdata <= DATA_W'(bit_cnt);
        ADDR_W'(OFS_ERRS):   reg_rdata <= DATA_W'(err_hold);
        ADDR_W'(OFS_STATUS): reg_rdata <= DATA_W'({in_sync, ovf_hold});
        default:             reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/bert_engine_chk.sv
module bert_engine_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_rd,
  input logic             cmp,
  input logic             err,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [CNT_W-1:0] err_cnt,
  input logic             ovf
);

  // R5: a mismatch is only ever reported for a compared bit
  a_r5_err_needs_cmp: assert property (@(posedge clk) disable iff (rst)
    err |-> cmp);

  // R5: the error count never passes the bit count
  a_r5_errs_within_bits: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= bit_cnt);

  // R8: without a clearing read the bit counter never goes down (no wrap)
  a_r8_bits_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !clr_rd |=> bit_cnt >= $past(bit_cnt));

  // R5: at most one bit counted per cycle
  a_r5_bits_step_one: assert property (@(posedge clk) disable iff (rst)
    !clr_rd |=> (bit_cnt - $past(bit_cnt)) <= CNT_W'(1));

  // R8: overflow flag is sticky until a clearing read
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_rd) |=> ovf);

  // R7: a clearing read leaves at most the same-cycle bit in the counter
  a_r7_clear_restarts: assert property (@(posedge clk) disable iff (rst)
    clr_rd |=> (bit_cnt <= CNT_W'(1)) && !ovf);

endmodule

bind bert_engine bert_engine_chk #(.CNT_W(CNT_W)) u_engine_chk (
  .clk    (clk),
  .rst    (rst),
  .clr_rd (clr_rd),
  .cmp    (cmp),
  .err    (err),
  .bit_cnt(bit_cnt),
  .err_cnt(err_cnt),
  .ovf    (ovf)
);

// File: tb/test_bert_engine.sv
`timescale 1ns/1ps
module test_bert_engine;

  localparam int CNT_W = 12;
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam logic [15:0] A_CTRL = 16'h1000, A_WORDS = 16'h1004, A_REP = 16'h1100,
                          A_BITS = 16'h1200, A_ERRS = 16'h1204, A_STAT = 16'h1208;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        tx_bit, tx_valid;
  logic        rx_en = 1'b0, rx_bit = 1'b0;

  int total = 0, bad = 0;

  bert_engine #(.CNT_W(CNT_W)) i_bert_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_bit(tx_bit), .tx_valid(tx_valid),
    .rx_en(rx_en), .rx_bit(rx_bit)
  );

  always #2 clk = ~clk;

  // capture of transmitted bits
  logic cap [0:1023];
  int   cap_n = 0;
  always @(negedge clk) if (tx_valid && cap_n < 1024) begin cap[cap_n] = tx_bit; cap_n++; end

  // receive-side source model
  logic [1:0]  src_mode;
  logic [15:0] src_a, src_b;
  int          src_rep, src_k;
  logic [14:0] src_lfsr;

  task automatic src_step(output logic b);
    int w;
    logic [15:0] cw;
    if (src_mode == 2'd0) begin
      b = src_lfsr[14] ^ src_lfsr[13];
      src_lfsr = {src_lfsr[13:0], b};
    end else begin
      w  = src_k / 16;
      cw = (src_mode == 2'd2 && ((w / src_rep) % 2) == 1) ? src_b : src_a;
      b  = cw[15 - (src_k % 16)];
    end
    src_k++;
  endtask

  function automatic logic word_model(int k, logic [1:0] m, logic [15:0] a, logic [15:0] b, int rep);
    int w = k / 16;
    logic [15:0] cw = (m == 2'd2 && ((w / rep) % 2) == 1) ? b : a;
    return cw[15 - (k % 16)];
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_rx(input int n, input logic inv, input int gap);
    logic b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_step(b);
      rx_en  = 1'b1;
      rx_bit = b ^ inv ^ ((gap != 0) && (i % gap == gap - 1));
    end
    @(negedge clk); rx_en = 1'b0;
  endtask

  // run the generator from a fresh mode and compare n bits with the model
  task automatic gen_run(input logic [1:0] m, input int n, input int rep, input string tag);
    logic [1:0] other = (m == 2'd1) ? 2'd2 : 2'd1;
    logic [14:0] s = '1;
    logic e;
    int errs = 0, first = -1;
    wr(A_CTRL, {30'd0, other});
    idle(2);
    cap_n = 0;
    wr(A_CTRL, 32'h4 | m);
    idle(n + 2);
    wr(A_CTRL, {30'd0, m});
    idle(2);
    for (int k = 0; k < n; k++) begin
      if (m == 2'd0) begin e = s[14] ^ s[13]; s = {s[13:0], e}; end
      else e = word_model(k, m, src_a, src_b, rep);
      if (cap[k] !== e) begin errs++; if (first < 0) first = k; end
    end
    check(errs == 0 && cap_n >= n, tag, first, -1);
  endtask

  logic [31:0] d, d2;
  int sum, nbits, gap, rep;
  bit stream_done;

  initial begin
    void'($urandom(32'h5eed_0b2e));
    idle(4);
    rst = 1'b0;
    idle(2);

    // R12 reset state
    check(tx_valid == 1'b0, "R12 tx_valid after reset", tx_valid, 0);
    check(reg_rdata == 0, "R12 rdata after reset", reg_rdata, 0);
    rd(A_BITS, d);
    check(d == 0, "R12 bit counter after reset", d, 0);

    // R9 generator disabled: no valid output
    wr(A_CTRL, 32'h0);
    cap_n = 0; idle(20);
    check(cap_n == 0, "R9 tx idle while disabled", cap_n, 0);

    // R1 pseudorandom generator
    gen_run(2'd0, 300, 1, "R1 prbs sequence");

    // R2 fixed word
    src_a = 16'($urandom); src_b = ~src_a;
    wr(A_WORDS, {src_b, src_a});
    gen_run(2'd1, 96, 1, "R2 fixed word stream");

    // R3 alternating with random repeat counts
    for (int t = 0; t < 3; t++) begin
      rep = 1 + ($urandom % 4);
      src_a = 16'($urandom); src_b = 16'($urandom);
      wr(A_WORDS, {src_b, src_a});
      wr(A_REP, rep);
      gen_run(2'd2, 16 * rep * 5, rep, "R3 alternating words");
    end
    // R3 repeat value 0 acts as 1
    wr(A_REP, 0);
    gen_run(2'd2, 160, 1, "R3 repeat zero as one");

    // R10 mode change restarts mid-repeat state
    wr(A_REP, 3);
    wr(A_CTRL, 32'h4 | 2'd2);
    idle(40);
    wr(A_CTRL, 32'h2);
    gen_run(2'd2, 192, 3, "R10 restart after mode change");

    // R11 single injected error
    wr(A_CTRL, 32'h1);
    idle(2);
    cap_n = 0;
    wr(A_CTRL, 32'h4);
    idle(20);
    wr(A_CTRL, 32'h14);
    idle(30);
    wr(A_CTRL, 32'h0);
    idle(2);
    begin
      logic [14:0] s = '1; logic e; int diff = 0;
      for (int k = 0; k < cap_n; k++) begin
        e = s[14] ^ s[13]; s = {s[13:0], e};
        if (cap[k] !== e) diff++;
      end
      check(diff == 1, "R11 exactly one inverted bit", diff, 1);
    end

    // R4 R5 checker, pseudorandom, random error spacing
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h8);
    src_mode = 2'd0; src_k = 0;
    src_lfsr = 15'($urandom) | 15'h1;
    drive_rx(40, 1'b0, 0);
    idle(3);
    rd(A_STAT, d);
    check(d[1] == 1'b1, "R4 prbs lock", d[1], 1);
    rd(A_BITS, d);
    for (int t = 0; t < 3; t++) begin
      nbits = 50 + ($urandom % 250);
      gap   = 6 + ($urandom % 35);
      drive_rx(nbits, 1'b0, gap);
      idle(4);
      rd(A_BITS, d);
      rd(A_ERRS, d2);
      check(d == nbits, "R5 compared bit count", d, nbits);
      check(d2 == nbits / gap, "R5 error count", d2, nbits / gap);
    end

    // R7 clearing reads landing on counted bits
    rd(A_BITS, d);
    sum = 0; stream_done = 0;
    fork
      begin drive_rx(2000, 1'b0, 0); stream_done = 1; end
      begin
        while (!stream_done) begin
          idle(1 + ($urandom % 40));
          rd(A_BITS, d); sum += d;
        end
      end
    join
    idle(4);
    rd(A_BITS, d); sum += d;
    check(sum == 2000, "R7 no bit lost or doubled across clears", sum, 2000);

    // R8 saturation and overflow flag
    drive_rx(CMAX + 100, 1'b0, 0);
    idle(4);
    rd(A_BITS, d);
    rd(A_STAT, d2);
    check(d == CMAX, "R8 counter saturates", d, CMAX);
    check(d2[0] == 1'b1, "R8 overflow flag set", d2[0], 1);
    rd(A_BITS, d);
    rd(A_STAT, d2);
    check(d == 0 && d2[0] == 1'b0, "R7 read cleared counter and flag", {d2[0], d[15:0]}, 0);

    // R9 checker disabled counts nothing
    wr(A_CTRL, 32'h0);
    drive_rx(100, 1'b0, 0);
    idle(4);
    rd(A_BITS, d);
    check(d == 0, "R9 nothing counted while checker off", d, 0);

    // R4 alternating lock
    rep = 1 + ($urandom % 3);
    src_mode = 2'd2; src_k = 0; src_rep = rep;
    src_a = 16'h3C5A; src_b = 16'hA1E7;
    wr(A_WORDS, {src_b, src_a});
    wr(A_REP, rep);
    wr(A_CTRL, 32'h8 | 2'd2);
    drive_rx(16 * (2 * rep + 3), 1'b0, 0);
    idle(3);
    rd(A_STAT, d);
    check(d[1] == 1'b1, "R4 alternating lock", d[1], 1);
    rd(A_BITS, d);
    drive_rx(200, 1'b0, 0);
    idle(4);
    rd(A_BITS, d);
    rd(A_ERRS, d2);
    check(d == 200 && d2 == 0, "R5 alternating clean count", d, 200);

    // R6 loss of lock in fixed mode
    src_mode = 2'd1; src_k = 0;
    src_a = 16'hF00D;
    wr(A_WORDS, {16'h0, src_a});
    wr(A_CTRL, 32'h8 | 2'd1);
    drive_rx(48, 1'b0, 0);
    idle(3);
    rd(A_STAT, d);
    check(d[1] == 1'b1, "R4 fixed word lock", d[1], 1);
    rd(A_BITS, d);
    drive_rx(40, 1'b1, 0);
    idle(4);
    rd(A_STAT, d);
    check(d[1] == 1'b0, "R6 lock dropped", d[1], 0);
    rd(A_BITS, d);
    rd(A_ERRS, d2);
    check(d == d2 && d2 >= 16 && d2 < 32, "R6 counting held after loss", d2, 16);
    drive_rx(48, 1'b0, 0);
    idle(3);
    rd(A_STAT, d);
    check(d[1] == 1'b1, "R6 relock after loss", d[1], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule